// File: doc/BRIEF.md
# Transmit-Only Serial Port Register Block

This block is the bus-facing register set of a legacy-style serial port that only transmits. A host uses a byte-wide bus with a 3-bit offset. Some writes land in configuration registers. A write to the data offset sends the byte to a downstream sink through a one-cycle strobe. There is no receiver, no bit timing and no FIFO storage. The divisor and FIFO-control values are exported as plain outputs, so a neighbouring baud or FIFO stage can use them.

Bit 7 of the line-control register selects the divisor bank. While that bit is set, only offsets 0 to 3 accept writes, and all reads are refused. An access that the block does not handle raises a combinational miss flag.

Interrupts follow a simple rule. An external periodic tick raises the transmit-empty interrupt when the enable allows it. Each byte written for transmission lowers the interrupt again. The identification register reflects the state of the line.

Top module: `txuart_regs`

## Requirements
- R1: After reset, every readable offset returns 0x00, except offset 2 (0x03), offset 5 (0x20) and offset 6 (0x10). After reset, `irq`, `tx_valid`, `divisor` and `fifo_ctl` are all zero.
- R2: With line-control bit 7 clear, a write to offset 0 is accepted with `miss` low. In the next cycle, `tx_valid` is high for exactly that one cycle and `tx_data` holds the written byte. Back-to-back writes produce one strobe per byte, in order.
- R3: With line-control bit 7 clear, the following offsets read back the last value written to them: offset 1 (interrupt enable), offset 3 (line control), offset 4 (modem control) and offset 7 (scratch). Offset 0 reads 0x00, and `miss` stays low.
- R4: Offset 5 always reads 0x20 and offset 6 always reads 0x10. Writes to offsets 5 and 6 raise `miss` and change neither read value.
- R5: With line-control bit 7 set, writes to offsets 0 and 1 update the low and high bytes of `divisor`. These writes send nothing and leave the interrupt enable unchanged. In the same mode, writes to offsets 2 and 3 update `fifo_ctl` and line control.
- R6: With line-control bit 7 set, writes to offsets 4 to 7 raise `miss` and change no register.
- R7: With line-control bit 7 set, every read raises `miss` and returns 0x00.
- R8: A `tick` pulse while interrupt-enable bit 1 is set makes `irq` high in the next cycle. After that, offset 2 reads 0x02.
- R9: A `tick` pulse while interrupt-enable bit 1 is clear leaves `irq` low and leaves offset 2 at 0x03.
- R10: A transmit write drives `irq` low in the next cycle. After that, offset 2 reads 0x03.
- R11: If a `tick` and a transmit write fall in the same cycle, the write wins and `irq` is low in the next cycle.
- R12: With line-control bit 7 clear, a write to offset 2 updates `fifo_ctl`. Reads of offset 2 still return the interrupt identification and not the FIFO-control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Bus access in this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, 0 when not a read hit |
| miss | output | 1 | Access not handled by the block |
| tick | input | 1 | Periodic transmit-empty interrupt request |
| tx_data | output | DATA_W | Transmitted byte |
| tx_valid | output | 1 | One-cycle strobe per transmitted byte |
| irq | output | 1 | Interrupt line |
| divisor | output | 2*DATA_W | Divisor latch {high, low} |
| fifo_ctl | output | DATA_W | FIFO control value |

## Verification
The bench builds the block with its default DATA_W of 8 and ADDR_W of 3. With these values, all eight offsets can be reached, and the bank bit sits at bit 7. Both banks can therefore be driven at every offset, including the four offsets that miss under the divisor bank. The 16-bit divisor output shows both latch bytes as one value, so a swapped low/high decode would show up directly. The tick is driven with the enable both set and clear, and also in the same cycle as a transmit write, so the priority rule is exercised from both interrupt states.

// File: rtl/txuart_pkg.sv
package txuart_pkg;
  localparam int unsigned OFF_DATA    = 0;
  localparam int unsigned OFF_IEN     = 1;
  localparam int unsigned OFF_ID      = 2;
  localparam int unsigned OFF_LINE    = 3;
  localparam int unsigned OFF_MODEM   = 4;
  localparam int unsigned OFF_LSTAT   = 5;
  localparam int unsigned OFF_MSTAT   = 6;
  localparam int unsigned OFF_SCRATCH = 7;

  localparam int unsigned BANK_BIT = 7;  // line control: divisor bank select
  localparam int unsigned TXIE_BIT = 1;  // interrupt enable: transmit empty

  localparam logic [7:0] LSTAT_VAL = 8'h20;
  localparam logic [7:0] MSTAT_VAL = 8'h10;

  typedef struct packed {
    logic thr;
    logic ien;
    logic fcr;
    logic lcr;
    logic mcr;
    logic scr;
    logic dll;
    logic dlm;
  } wstb_t;

  // identification byte: source code 0x02, bit 0 set when nothing pending
  function automatic logic [7:0] id_value(input logic pending);
    return pending ? 8'h02 : 8'h03;
  endfunction
endpackage

// File: rtl/txuart_decode.sv
module txuart_decode
  import txuart_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  output wstb_t             wstb,
  output logic              rd_hit,
  output logic              miss
);
  localparam int unsigned TOP_OFF = OFF_SCRATCH;

  always_comb begin
    wstb   = '0;
    rd_hit = 1'b0;
    miss   = 1'b0;
    if (sel) begin
      if (we) begin
        if (bank) begin
          case (int'(addr))
            OFF_DATA: wstb.dll = 1'b1;
            OFF_IEN:  wstb.dlm = 1'b1;
            OFF_ID:   wstb.fcr = 1'b1;
            OFF_LINE: wstb.lcr = 1'b1;
            default:  miss     = 1'b1;
          endcase
        end else begin
          case (int'(addr))
            OFF_DATA:    wstb.thr = 1'b1;
            OFF_IEN:     wstb.ien = 1'b1;
            OFF_ID:      wstb.fcr = 1'b1;
            OFF_LINE:    wstb.lcr = 1'b1;
            OFF_MODEM:   wstb.mcr = 1'b1;
            OFF_SCRATCH: wstb.scr = 1'b1;
            default:     miss     = 1'b1;
          endcase
        end
      end else begin
        if (bank || (int'(addr) > int'(TOP_OFF))) miss = 1'b1;
        else rd_hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/txuart_irq.sv
module txuart_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic clear,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pending <= 1'b0;
    else if (clear)           pending <= 1'b0;
    else if (tick && enable)  pending <= 1'b1;
  end

  AST_TICK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable && !clear) |=> pending);  // R8
  AST_TICK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clear) |=> pending == $past(pending));  // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !pending);  // R11
endmodule

// File: rtl/txuart_regs.sv
module txuart_regs
  import txuart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  output logic                  miss,
  input  logic                  tick,
  output logic [DATA_W-1:0]     tx_data,
  output logic                  tx_valid,
  output logic                  irq,
  output logic [2*DATA_W-1:0]   divisor,
  output logic [DATA_W-1:0]     fifo_ctl
);
  localparam int DIV_W = 2 * DATA_W;

  logic [DATA_W-1:0] ien_q, lcr_q, mcr_q, scr_q, fcr_q, dll_q, dlm_q;
  logic [DATA_W-1:0] txd_q;
  logic              txv_q;
  logic              pend;

  // named internal events
  wstb_t wstb;
  logic  rd_hit;
  logic  bank_on;
  logic  tx_push;
  logic  rd_lstat, rd_id;

  assign bank_on = lcr_q[BANK_BIT];

  txuart_decode #(.ADDR_W(ADDR_W)) i_decode (
    .sel    (sel),
    .we     (we),
    .addr   (addr),
    .bank   (bank_on),
    .wstb   (wstb),
    .rd_hit (rd_hit),
    .miss   (miss)
  );

  assign tx_push = wstb.thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0; lcr_q <= '0; mcr_q <= '0; scr_q <= '0;
      fcr_q <= '0; dll_q <= '0; dlm_q <= '0;
    end else begin
      if (wstb.ien) ien_q <= wdata;
      if (wstb.lcr) lcr_q <= wdata;
      if (wstb.mcr) mcr_q <= wdata;
      if (wstb.scr) scr_q <= wdata;
      if (wstb.fcr) fcr_q <= wdata;
      if (wstb.dll) dll_q <= wdata;
      if (wstb.dlm) dlm_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= '0;
      txv_q <= 1'b0;
    end else begin
      txv_q <= tx_push;
      if (tx_push) txd_q <= wdata;
    end
  end

  txuart_irq i_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .enable  (ien_q[TXIE_BIT]),
    .clear   (tx_push),
    .pending (pend)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      case (int'(addr))
        OFF_IEN:     rdata = ien_q;
        OFF_ID:      rdata = DATA_W'(id_value(pend));
        OFF_LINE:    rdata = lcr_q;
        OFF_MODEM:   rdata = mcr_q;
        OFF_LSTAT:   rdata = DATA_W'(LSTAT_VAL);
        OFF_MSTAT:   rdata = DATA_W'(MSTAT_VAL);
        OFF_SCRATCH: rdata = scr_q;
        default:     rdata = '0;
      endcase
    end
  end

  assign tx_data  = txd_q;
  assign tx_valid = txv_q;
  assign irq      = pend;
  assign divisor  = DIV_W'({dlm_q, dll_q});
  assign fifo_ctl = fcr_q;

  assign rd_lstat = sel && !we && !bank_on && (int'(addr) == OFF_LSTAT);
  assign rd_id    = sel && !we && !bank_on && (int'(addr) == OFF_ID);

  AST_TX_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && !bank_on && int'(addr) == OFF_DATA) |=> (tx_valid && tx_data == $past(wdata)));  // R2
  AST_NO_TX_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    bank_on |=> !tx_valid);  // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb));  // R5
  AST_BANK_READ_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && bank_on) |-> (miss && rdata == '0));  // R7
  AST_LSTAT_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lstat |-> (rdata == DATA_W'(8'h20) && !miss));  // R4
  AST_ID_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id |-> (rdata[0] == !irq));  // R8
endmodule

// File: tb/test_txuart_regs.sv
`timescale 1ns/1ps
module test_txuart_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, we = 1'b0, tick = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tx_data, fifo_ctl;
  logic [15:0] divisor;
  logic       miss, tx_valid, irq;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  txuart_regs i_txuart_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .miss(miss), .tick(tick), .tx_data(tx_data),
    .tx_valid(tx_valid), .irq(irq), .divisor(divisor), .fifo_ctl(fifo_ctl)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one bus write; transmit writes push the expected byte
  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic m);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 m = miss;
    if (m === 1'b0 && a == 3'd0 && !i_bank_model) exp_q.push_back(d);
    @(posedge clk);
    #1 sel = 1'b0; we = 1'b0;
    if (m === 1'b0 && a == 3'd3) i_bank_model = d[7];
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic m);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata; m = miss;
    @(posedge clk);
    #1 sel = 1'b0;
  endtask

  task automatic pulse_tick(input bit with_tx, input logic [7:0] d);
    @(negedge clk);
    tick = 1'b1;
    if (with_tx) begin
      sel = 1'b1; we = 1'b1; addr = 3'd0; wdata = d;
      exp_q.push_back(d);
    end
    @(posedge clk);
    #1 tick = 1'b0; sel = 1'b0; we = 1'b0;
  endtask

  bit i_bank_model = 1'b0;

  // monitor: compare every strobe with the scoreboard
  always @(negedge clk) begin
    if (rst_n && tx_valid === 1'b1) begin
      if (exp_q.size() == 0) chk("R2/R5 unexpected tx", {24'h0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 tx byte", {24'h0, tx_data}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 tx_valid", tx_valid, 0);
    chk("R1 divisor", divisor, 0); chk("R1 fifo_ctl", fifo_ctl, 0);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      e = (i == 2) ? 8'h03 : (i == 5) ? 8'h20 : (i == 6) ? 8'h10 : 8'h00;
      rd(3'(i), d, m);
      chk("R1 reset read", d, e);
      chk("R1 read miss", m, 0);
    end
    // R3 readback
    wr(3'd1, 8'h05, m); chk("R3 ien miss", m, 0);
    wr(3'd3, 8'h1B, m); chk("R3 lcr miss", m, 0);
    wr(3'd4, 8'h0A, m); chk("R3 mcr miss", m, 0);
    wr(3'd7, 8'hA5, m); chk("R3 scr miss", m, 0);
    rd(3'd1, d, m); chk("R3 ien", d, 8'h05);
    rd(3'd3, d, m); chk("R3 lcr", d, 8'h1B);
    rd(3'd4, d, m); chk("R3 mcr", d, 8'h0A);
    rd(3'd7, d, m); chk("R3 scr", d, 8'hA5); chk("R3 miss", m, 0);
    // R2 transmit, including back-to-back
    wr(3'd0, 8'h41, m); chk("R2 accept", m, 0);
    wr(3'd0, 8'h42, m);
    wr(3'd0, 8'h7E, m);
    rd(3'd0, d, m); chk("R3 offset0 read", d, 8'h00);
    // R4 status constants and refused writes
    wr(3'd5, 8'hFF, m); chk("R4 write5 miss", m, 1);
    wr(3'd6, 8'hFF, m); chk("R4 write6 miss", m, 1);
    rd(3'd5, d, m); chk("R4 lstat", d, 8'h20);
    rd(3'd6, d, m); chk("R4 mstat", d, 8'h10);
    // R12 fifo control vs id
    wr(3'd2, 8'hC7, m); chk("R12 miss", m, 0);
    @(negedge clk); chk("R12 fifo_ctl", fifo_ctl, 8'hC7);
    rd(3'd2, d, m); chk("R12 id read", d, 8'h03);
    // R9 tick with enable clear
    pulse_tick(0, 8'h00);
    @(negedge clk); chk("R9 irq", irq, 0);
    rd(3'd2, d, m); chk("R9 id", d, 8'h03);
    // R8 tick with enable set
    wr(3'd1, 8'h02, m);
    pulse_tick(0, 8'h00);
    @(negedge clk); chk("R8 irq", irq, 1);
    rd(3'd2, d, m); chk("R8 id", d, 8'h02);
    // R10 transmit clears
    wr(3'd0, 8'h55, m);
    @(negedge clk); chk("R10 irq", irq, 0);
    rd(3'd2, d, m); chk("R10 id", d, 8'h03);
    // R11 same-cycle collision, from pending and from idle
    pulse_tick(0, 8'h00);
    @(negedge clk); chk("R8 irq again", irq, 1);
    pulse_tick(1, 8'h66);
    @(negedge clk); chk("R11 irq from pending", irq, 0);
    pulse_tick(1, 8'h67);
    @(negedge clk); chk("R11 irq from idle", irq, 0);
    // R5 divisor bank
    wr(3'd3, 8'h83, m); chk("R5 lcr miss", m, 0);
    wr(3'd0, 8'h34, m); chk("R5 dll miss", m, 0);
    wr(3'd1, 8'h12, m); chk("R5 dlm miss", m, 0);
    wr(3'd2, 8'h81, m);
    @(negedge clk);
    chk("R5 divisor", divisor, 16'h1234);
    chk("R5 fifo_ctl", fifo_ctl, 8'h81);
    // R7 reads refused
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d, m);
      chk("R7 miss", m, 1);
      chk("R7 rdata", d, 8'h00);
    end
    // R6 upper writes refused
    for (int i = 4; i < 8; i++) begin
      wr(3'(i), 8'hEE, m);
      chk("R6 miss", m, 1);
    end
    wr(3'd3, 8'h03, m); chk("R5 lcr write in bank", m, 0);
    rd(3'd3, d, m); chk("R5 lcr", d, 8'h03);
    rd(3'd1, d, m); chk("R5 ien unchanged", d, 8'h02);
    rd(3'd4, d, m); chk("R6 mcr unchanged", d, 8'h0A);
    rd(3'd7, d, m); chk("R6 scr unchanged", d, 8'hA5);
    chk("R5 divisor kept", divisor, 16'h1234);
    repeat (4) @(negedge clk);
    chk("R2 queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule